// File: doc/BRIEF.md
# Interval Operation Flag Generator

This block sits in front of the two endpoint datapaths of an interval arithmetic unit. Each cycle it may accept one command and two operand intervals, X = [xLo, xHi] and Y = [yLo, yHi]. It then tells the lower-bound path and the upper-bound path what to do. For each path it gives an operation select and the pair of operand endpoints that path must combine.

Addition and subtraction always use a fixed endpoint pairing. For subtraction the pairing is crossed, so that the result bounds every point difference. Multiplication first sorts each operand into one of three sign classes: wholly nonnegative, wholly negative, or straddling zero. The pair of classes gives nine cases, and each case picks the endpoint products that bound the result. When both operands straddle zero, no single product is known to be the bound. The block then names two candidate products per bound and raises a flag so that the datapath keeps the smaller (lower bound) or the larger (upper bound).

Division is limited to powers of two. It becomes an arithmetic shift of both X endpoints, so a zero divisor cannot occur. Independently of the command, the block also reports whether the two intervals overlap at all. All results are registered and appear one cycle after the command.

Top module: `interval_flag_gen`

## Requirements
- R1: Every output is zero while reset is held. `outValid` is high in exactly the cycle after a cycle with `cmdValid` high, and low otherwise.
- R2: In a cycle with `cmdValid` low, every output except `outValid` keeps the value it had, whatever the other inputs do.
- R3: Command code 0 (add) sets both ops to 0 (ADD). The lower pair is 2'b00 (xLo,yLo) and the upper pair is 2'b11 (xHi,yHi). In every pair code, bit 1 selects the X endpoint (0 = xLo, 1 = xHi) and bit 0 selects the Y endpoint (0 = yLo, 1 = yHi).
- R4: Command code 1 (subtract) sets both ops to 1 (SUB). The lower pair is 2'b01 (xLo−yHi) and the upper pair is 2'b10 (xHi−yLo).
- R5: Each operand is classed 0 if its low endpoint is ≥ 0, else 1 if its high endpoint is < 0, else 2 (straddles zero). `mulCase` = 3·classX + classY, and it is reported for every command.
- R6: Command code 2 (multiply) sets both ops to 2 (MUL). In the eight cases other than 8, `pickNeeded` is 0, each alternate pair equals its primary pair, and the pairs follow the sign table.
- R7: Multiply in case 8 gives lower pairs 2'b01 and 2'b10, upper pairs 2'b00 and 2'b11, and `pickNeeded` = 1.
- R8: Command code 3 (divide by 2^k) sets both ops to 3 (SHR), the lower pair to 2'b00 and the upper pair to 2'b10, and copies `shiftIn` to `shiftOut`. Every other command gives `shiftOut` = 0.
- R9: `disjoint` is 1 exactly when yHi < xLo or xHi < yLo, compared as two's-complement signed values. Endpoints that touch are not disjoint.
- R10: For add, subtract and multiply, evaluate the selected pairs (taking the minimum of the two lower candidates and the maximum of the two upper candidates). The result equals the exact bounds of the set of point results, e.g. [1,2]+[3,4] gives [4,6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdCode | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide by power of two |
| shiftIn | input | SHW | Power-of-two exponent for divide |
| xLo | input | W | Lower endpoint of X, signed |
| xHi | input | W | Upper endpoint of X, signed |
| yLo | input | W | Lower endpoint of Y, signed |
| yHi | input | W | Upper endpoint of Y, signed |
| outValid | output | 1 | Registered outputs belong to a new command |
| loOp | output | 2 | Operation select for the lower-bound path |
| hiOp | output | 2 | Operation select for the upper-bound path |
| loPair | output | 2 | Primary endpoint pair for the lower bound |
| loPairAlt | output | 2 | Second lower-bound candidate pair |
| hiPair | output | 2 | Primary endpoint pair for the upper bound |
| hiPairAlt | output | 2 | Second upper-bound candidate pair |
| pickNeeded | output | 1 | Datapath must take min/max over the two candidates |
| mulCase | output | 4 | Sign-class case index 0..8 |
| disjoint | output | 1 | Operand intervals do not overlap |
| shiftOut | output | SHW | Shift amount for divide, else zero |

## Verification
The hardest situation to reach is the straddle-straddle product case. Only there does the correctness of the selection depend on a later min/max, so the pairs cannot be judged on their own. The stimulus table drives that case with small mixed-sign intervals and with the full signed range on both operands. The bench then evaluates every selected pair with the real endpoint values and compares the result with the exact bounds taken over all four products. The disjoint compare is also pushed to its edges, with touching endpoints, a single-point interval at zero, and operands that are entirely negative.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_SHR = 2'd3
  } opSel_e;

  typedef enum logic [1:0] {
    CLS_NONNEG   = 2'd0,
    CLS_NEG      = 2'd1,
    CLS_STRADDLE = 2'd2
  } signCls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic doAdd;
    logic doSub;
    logic doMul;
    logic doShr;
  } ctrlStrobe_t;

  // pair code: bit1 selects X endpoint (0 lo, 1 hi), bit0 selects Y endpoint
  localparam logic [1:0] PAIR_LL = 2'b00;
  localparam logic [1:0] PAIR_LU = 2'b01;
  localparam logic [1:0] PAIR_UL = 2'b10;
  localparam logic [1:0] PAIR_UU = 2'b11;

  localparam int unsigned NUM_CLS  = 3;
  localparam int unsigned CASE_W   = 4;
  localparam logic [CASE_W-1:0] CASE_BOTH_STRADDLE = CASE_W'(NUM_CLS * NUM_CLS - 1);

endpackage

// File: rtl/ifg_sign_class.sv
module ifg_sign_class
  import ifg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] lo,
  input  logic signed [W-1:0] hi,
  output signCls_e            cls
);

  always_comb begin
    if (!lo[W-1]) begin
      cls = CLS_NONNEG;
    end else if (hi[W-1]) begin
      cls = CLS_NEG;
    end else begin
      cls = CLS_STRADDLE;
    end
  end

endmodule

// File: rtl/ifg_ctrl.sv
module ifg_ctrl
  import ifg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdCode,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe      = '0;
    strobe.load = cmdValid;
    if (cmdValid) begin
      case (cmdCode)
        2'd0:    strobe.doAdd = 1'b1;
        2'd1:    strobe.doSub = 1'b1;
        2'd2:    strobe.doMul = 1'b1;
        default: strobe.doShr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= cmdValid;
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R1: result flag follows the command by exactly one cycle
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (outValid == $past(cmdValid)));

endmodule

// File: rtl/ifg_dpath.sv
module ifg_dpath
  import ifg_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned SHW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [SHW-1:0]      shiftIn,
  input  logic signed [W-1:0] xLo,
  input  logic signed [W-1:0] xHi,
  input  logic signed [W-1:0] yLo,
  input  logic signed [W-1:0] yHi,
  output opSel_e              loOpQ,
  output opSel_e              hiOpQ,
  output logic [1:0]          loPairQ,
  output logic [1:0]          loAltQ,
  output logic [1:0]          hiPairQ,
  output logic [1:0]          hiAltQ,
  output logic                pickQ,
  output logic [CASE_W-1:0]   mulCaseQ,
  output logic                disjointQ,
  output logic [SHW-1:0]      shiftQ
);

  localparam int unsigned NUM_OPND = 2;

  // ---------------- sign classification ----------------
  logic signed [W-1:0] opLo [NUM_OPND];
  logic signed [W-1:0] opHi [NUM_OPND];
  signCls_e            opCls [NUM_OPND];

  assign opLo[0] = xLo;
  assign opHi[0] = xHi;
  assign opLo[1] = yLo;
  assign opHi[1] = yHi;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_cls
    ifg_sign_class #(.W(W)) u_cls (
      .lo  (opLo[g]),
      .hi  (opHi[g]),
      .cls (opCls[g])
    );
  end

  logic [CASE_W-1:0] caseIdx;
  assign caseIdx = CASE_W'(opCls[0]) * CASE_W'(NUM_CLS) + CASE_W'(opCls[1]);

  // ---------------- disjoint cross compare ----------------
  logic yBelowX, xBelowY, disjointD;
  assign yBelowX   = (yHi < xLo);
  assign xBelowY   = (xHi < yLo);
  assign disjointD = yBelowX | xBelowY;

  // ---------------- endpoint pair selection ----------------
  opSel_e         loOpD, hiOpD;
  logic [1:0]     loPairD, loAltD, hiPairD, hiAltD;
  logic           pickD;
  logic [SHW-1:0] shiftD;

  always_comb begin
    loOpD   = OP_ADD;
    hiOpD   = OP_ADD;
    loPairD = PAIR_LL;
    hiPairD = PAIR_UU;
    loAltD  = PAIR_LL;
    hiAltD  = PAIR_UU;
    pickD   = 1'b0;
    shiftD  = '0;
    if (strobe.doSub) begin
      loOpD   = OP_SUB;
      hiOpD   = OP_SUB;
      loPairD = PAIR_LU;
      hiPairD = PAIR_UL;
    end else if (strobe.doMul) begin
      loOpD = OP_MUL;
      hiOpD = OP_MUL;
      case (caseIdx)
        4'd0: begin loPairD = PAIR_LL; hiPairD = PAIR_UU; end // +,+
        4'd1: begin loPairD = PAIR_UL; hiPairD = PAIR_LU; end // +,-
        4'd2: begin loPairD = PAIR_UL; hiPairD = PAIR_UU; end // +,0
        4'd3: begin loPairD = PAIR_LU; hiPairD = PAIR_UL; end // -,+
        4'd4: begin loPairD = PAIR_UU; hiPairD = PAIR_LL; end // -,-
        4'd5: begin loPairD = PAIR_LU; hiPairD = PAIR_LL; end // -,0
        4'd6: begin loPairD = PAIR_LU; hiPairD = PAIR_UU; end // 0,+
        4'd7: begin loPairD = PAIR_UL; hiPairD = PAIR_LL; end // 0,-
        default: begin                                          // 0,0
          loPairD = PAIR_LU;
          hiPairD = PAIR_LL;
          pickD   = 1'b1;
        end
      endcase
    end else if (strobe.doShr) begin
      loOpD   = OP_SHR;
      hiOpD   = OP_SHR;
      loPairD = PAIR_LL;
      hiPairD = PAIR_UL;
      shiftD  = shiftIn;
    end
    if (pickD) begin
      loAltD = PAIR_UL;
      hiAltD = PAIR_UU;
    end else begin
      loAltD = loPairD;
      hiAltD = hiPairD;
    end
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loOpQ     <= OP_ADD;
      hiOpQ     <= OP_ADD;
      loPairQ   <= '0;
      loAltQ    <= '0;
      hiPairQ   <= '0;
      hiAltQ    <= '0;
      pickQ     <= 1'b0;
      mulCaseQ  <= '0;
      disjointQ <= 1'b0;
      shiftQ    <= '0;
    end else if (strobe.load) begin
      loOpQ     <= loOpD;
      hiOpQ     <= hiOpD;
      loPairQ   <= loPairD;
      loAltQ    <= loAltD;
      hiPairQ   <= hiPairD;
      hiAltQ    <= hiAltD;
      pickQ     <= pickD;
      mulCaseQ  <= caseIdx;
      disjointQ <= disjointD;
      shiftQ    <= shiftD;
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R2: without a command the registered decision is frozen
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(strobe.load)) |->
      ($stable(loPairQ) && $stable(hiPairQ) && $stable(disjointQ) && $stable(mulCaseQ)));

  // R7: a min/max request only ever comes from the straddle-straddle product
  p_pick_zz_r7: assert property (@(posedge clk) disable iff (!rstN)
    pickQ |-> (mulCaseQ == CASE_BOTH_STRADDLE && loOpQ == OP_MUL && hiOpQ == OP_MUL));

  // R6: with no selection pending, the alternate candidate repeats the primary
  p_alt_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pickQ |-> (loAltQ == loPairQ && hiAltQ == hiPairQ));

  // R8: shift operation always scales the two X endpoints
  p_div_pairs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loOpQ == OP_SHR) |-> (loPairQ == PAIR_LL && hiPairQ == PAIR_UL && hiOpQ == OP_SHR));

endmodule

// File: rtl/interval_flag_gen.sv
module interval_flag_gen
  import ifg_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned SHW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdCode,
  input  logic [SHW-1:0]       shiftIn,
  input  logic signed [W-1:0]  xLo,
  input  logic signed [W-1:0]  xHi,
  input  logic signed [W-1:0]  yLo,
  input  logic signed [W-1:0]  yHi,
  output logic                 outValid,
  output logic [1:0]           loOp,
  output logic [1:0]           hiOp,
  output logic [1:0]           loPair,
  output logic [1:0]           loPairAlt,
  output logic [1:0]           hiPair,
  output logic [1:0]           hiPairAlt,
  output logic                 pickNeeded,
  output logic [CASE_W-1:0]    mulCase,
  output logic                 disjoint,
  output logic [SHW-1:0]       shiftOut
);

  ctrlStrobe_t strobe;
  opSel_e      loOpQ, hiOpQ;

  ifg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ifg_dpath #(.W(W), .SHW(SHW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .shiftIn   (shiftIn),
    .xLo       (xLo),
    .xHi       (xHi),
    .yLo       (yLo),
    .yHi       (yHi),
    .loOpQ     (loOpQ),
    .hiOpQ     (hiOpQ),
    .loPairQ   (loPair),
    .loAltQ    (loPairAlt),
    .hiPairQ   (hiPair),
    .hiAltQ    (hiPairAlt),
    .pickQ     (pickNeeded),
    .mulCaseQ  (mulCase),
    .disjointQ (disjoint),
    .shiftQ    (shiftOut)
  );

  assign loOp = loOpQ;
  assign hiOp = hiOpQ;

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R9: overlap flag matches the signed cross comparison of the accepted operands
  p_disjoint_r9: assert property (@(posedge clk) disable iff (!rstN)
    (primed && outValid) |->
      (disjoint == (($past(yHi) < $past(xLo)) || ($past(xHi) < $past(yLo)))));

  // R8: only a shift command may carry a nonzero shift amount
  p_shift_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loOp != 2'd3) |-> (shiftOut == '0));

  // R1: a command code of shift is reflected in both op selects together
  p_op_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    (primed && outValid) |-> (loOp == hiOp && loOp == $past(cmdCode)));

endmodule

// File: tb/interval_flag_gen_bench.sv
module interval_flag_gen_bench;

  localparam int W     = 16;
  localparam int SHW   = 4;
  localparam int VEC_W = 83;
  localparam int NVEC  = 16;

  // {cmd, shift[3], xl, xh, yl, yh, lo, loA, hi, hiA, pick, case[4], disj}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 16'sd1,  16'sd2,  16'sd3,  16'sd4,  2'b00,2'b00,2'b11,2'b11,1'b0,4'd0,1'b1},
    {2'd1, 3'd0, 16'sd5,  16'sd9,  -16'sd2, 16'sd3,  2'b01,2'b01,2'b10,2'b10,1'b0,4'd2,1'b1},
    {2'd2, 3'd0, 16'sd1,  16'sd2,  16'sd3,  16'sd4,  2'b00,2'b00,2'b11,2'b11,1'b0,4'd0,1'b1},
    {2'd2, 3'd0, 16'sd1,  16'sd2,  -16'sd4, -16'sd3, 2'b10,2'b10,2'b01,2'b01,1'b0,4'd1,1'b1},
    {2'd2, 3'd0, 16'sd1,  16'sd2,  -16'sd3, 16'sd4,  2'b10,2'b10,2'b11,2'b11,1'b0,4'd2,1'b0},
    {2'd2, 3'd0, -16'sd2, -16'sd1, 16'sd3,  16'sd4,  2'b01,2'b01,2'b10,2'b10,1'b0,4'd3,1'b1},
    {2'd2, 3'd0, -16'sd2, -16'sd1, -16'sd4, -16'sd3, 2'b11,2'b11,2'b00,2'b00,1'b0,4'd4,1'b1},
    {2'd2, 3'd0, -16'sd2, -16'sd1, -16'sd3, 16'sd4,  2'b01,2'b01,2'b00,2'b00,1'b0,4'd5,1'b0},
    {2'd2, 3'd0, -16'sd3, 16'sd4,  16'sd1,  16'sd2,  2'b01,2'b01,2'b11,2'b11,1'b0,4'd6,1'b0},
    {2'd2, 3'd0, -16'sd3, 16'sd4,  -16'sd2, -16'sd1, 2'b10,2'b10,2'b00,2'b00,1'b0,4'd7,1'b0},
    {2'd2, 3'd0, -16'sd3, 16'sd4,  -16'sd5, 16'sd2,  2'b01,2'b10,2'b00,2'b11,1'b1,4'd8,1'b0},
    {2'd3, 3'd3, -16'sd8, 16'sd6,  16'sd0,  16'sd0,  2'b00,2'b00,2'b10,2'b10,1'b0,4'd6,1'b0},
    {2'd2, 3'd0, 16'sd0,  16'sd0,  -16'sd1, -16'sd1, 2'b10,2'b10,2'b01,2'b01,1'b0,4'd1,1'b1},
    {2'd2, 3'd0, 16'h8000,16'h7FFF,16'h8000,16'h7FFF,2'b01,2'b10,2'b00,2'b11,1'b1,4'd8,1'b0},
    {2'd0, 3'd5, 16'sd1,  16'sd3,  16'sd3,  16'sd5,  2'b00,2'b00,2'b11,2'b11,1'b0,4'd0,1'b0},
    {2'd1, 3'd0, -16'sd5, -16'sd4, 16'sd10, 16'sd20, 2'b01,2'b01,2'b10,2'b10,1'b0,4'd3,1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdCode = '0;
  logic [SHW-1:0] shiftIn = '0;
  logic signed [W-1:0] xLo = '0, xHi = '0, yLo = '0, yHi = '0;
  logic outValid, pickNeeded, disjoint;
  logic [1:0] loOp, hiOp, loPair, loPairAlt, hiPair, hiPairAlt;
  logic [3:0] mulCase;
  logic [SHW-1:0] shiftOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_flag_gen #(.W(W), .SHW(SHW)) u_interval_flag_gen (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode), .shiftIn(shiftIn),
    .xLo(xLo), .xHi(xHi), .yLo(yLo), .yHi(yHi), .outValid(outValid),
    .loOp(loOp), .hiOp(hiOp), .loPair(loPair), .loPairAlt(loPairAlt),
    .hiPair(hiPair), .hiPairAlt(hiPairAlt), .pickNeeded(pickNeeded),
    .mulCase(mulCase), .disjoint(disjoint), .shiftOut(shiftOut)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint evalPair(input logic [1:0] cmd, input logic [1:0] pc,
                                      input longint xl, input longint xh,
                                      input longint yl, input longint yh);
    longint a, b;
    a = pc[1] ? xh : xl;
    b = pc[0] ? yh : yl;
    case (cmd)
      2'd0:    return a + b;
      2'd1:    return a - b;
      default: return a * b;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] lastLo, lastHi;
    logic [3:0] lastCase;
    logic lastDisj;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid in reset", outValid, 0);
    chk("R1 loPair in reset", loPair, 0);
    chk("R1 hiPair in reset", hiPair, 0);
    chk("R1 disjoint in reset", disjoint, 0);
    chk("R1 mulCase in reset", mulCase, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid idle", outValid, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] v;
      logic [1:0] cmd;
      logic [2:0] sh;
      longint xl, xh, yl, yh, tLo, tHi, sLo, sHi, p0, p1, p2, p3;
      v   = VEC[i];
      cmd = v[82:81];
      sh  = v[80:78];
      cmdValid = 1'b1;
      cmdCode  = cmd;
      shiftIn  = SHW'(sh);
      xLo = v[77:62]; xHi = v[61:46]; yLo = v[45:30]; yHi = v[29:14];
      xl = longint'(xLo); xh = longint'(xHi); yl = longint'(yLo); yh = longint'(yHi);
      @(negedge clk);
      chk("R1 outValid after command", outValid, 1);
      chk("R3/R4/R6/R8 loOp", loOp, cmd);
      chk("R3/R4/R6/R8 hiOp", hiOp, cmd);
      chk("R3/R4/R6/R7 loPair", loPair, v[13:12]);
      chk("R6/R7 loPairAlt", loPairAlt, v[11:10]);
      chk("R3/R4/R6/R7 hiPair", hiPair, v[9:8]);
      chk("R6/R7 hiPairAlt", hiPairAlt, v[7:6]);
      chk("R7 pickNeeded", pickNeeded, v[5]);
      chk("R5 mulCase", mulCase, v[4:1]);
      chk("R9 disjoint", disjoint, v[0]);
      chk("R8 shiftOut", shiftOut, (cmd == 2'd3) ? longint'(sh) : 0);
      if (cmd != 2'd3) begin
        // R10: evaluate chosen pairs against exact bounds
        p0 = evalPair(cmd, 2'b00, xl, xh, yl, yh);
        p1 = evalPair(cmd, 2'b01, xl, xh, yl, yh);
        p2 = evalPair(cmd, 2'b10, xl, xh, yl, yh);
        p3 = evalPair(cmd, 2'b11, xl, xh, yl, yh);
        if (cmd == 2'd0) begin tLo = xl + yl; tHi = xh + yh; end
        else if (cmd == 2'd1) begin tLo = xl - yh; tHi = xh - yl; end
        else begin
          tLo = p0; tHi = p0;
          if (p1 < tLo) tLo = p1; if (p2 < tLo) tLo = p2; if (p3 < tLo) tLo = p3;
          if (p1 > tHi) tHi = p1; if (p2 > tHi) tHi = p2; if (p3 > tHi) tHi = p3;
        end
        sLo = evalPair(cmd, loPair, xl, xh, yl, yh);
        p0  = evalPair(cmd, loPairAlt, xl, xh, yl, yh);
        if (p0 < sLo) sLo = p0;
        sHi = evalPair(cmd, hiPair, xl, xh, yl, yh);
        p0  = evalPair(cmd, hiPairAlt, xl, xh, yl, yh);
        if (p0 > sHi) sHi = p0;
        chk("R10 lower bound exact", sLo, tLo);
        chk("R10 upper bound exact", sHi, tHi);
      end
    end

    // R2: hold with no command, changed inputs
    lastLo = loPair; lastHi = hiPair; lastCase = mulCase; lastDisj = disjoint;
    cmdValid = 1'b0;
    cmdCode  = 2'd2;
    shiftIn  = 4'd7;
    xLo = -16'sd3; xHi = 16'sd4; yLo = -16'sd5; yHi = 16'sd2;
    @(negedge clk);
    chk("R1 outValid drops", outValid, 0);
    chk("R2 loPair held", loPair, lastLo);
    chk("R2 hiPair held", hiPair, lastHi);
    chk("R2 mulCase held", mulCase, lastCase);
    chk("R2 disjoint held", disjoint, lastDisj);
    chk("R2 pickNeeded held", pickNeeded, 0);
    @(negedge clk);
    chk("R2 loOp held", loOp, 2'd1);
    chk("R2 shiftOut held", shiftOut, 0);

    // R1/R7: command after idle gap is taken
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 pickNeeded after gap", pickNeeded, 1);
    chk("R5 mulCase after gap", mulCase, 8);
    @(negedge clk);
    chk("R1 outValid single pulse", outValid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule